// File: doc/BRIEF.md
# Majority-Vote Multiprocessor Serial Receiver

This block is an asynchronous serial receiver driven by a clock enable that pulses sixteen times per bit period. It watches the serial line through a two-flop synchronizer and starts a frame on a high-to-low transition. Each bit is decided by a two-out-of-three vote over samples taken on the 7th, 8th and 9th enable ticks of the bit. A start bit that does not vote low is treated as noise: the frame is dropped and the receiver goes back to looking for a falling edge.

Two frame shapes are supported. In 8-bit mode a frame is a start bit, eight data bits sent least significant bit first, and a stop bit. The stop bit is shifted in one extra position and lands in the ninth-bit output. In 9-bit mode a ninth data bit comes after the eight data bits and lands in the ninth-bit output, followed by the stop bit. At the middle of the final bit the receiver decides whether to commit the frame. It commits only when the done flag is clear and either multiprocessor addressing is off or the ninth-bit value is 1. It then returns to edge search.

The done flag stays high until software pulses the clear input. This allows a node on a shared line to ignore data frames (ninth bit 0) while it waits for address frames (ninth bit 1).

Top module: `mpr_rx`

## Requirements
- R1: After reset the data output, the ninth-bit output and the done flag are all 0.
- R2: In 8-bit mode (nine_bit_mode = 0) a frame of start 0, eight data bits LSB first, and stop bit puts the data bits on rx_data. The stop value goes on rx_bit9 and rx_done is set.
- R3: In 9-bit mode (nine_bit_mode = 1) the bit after the eight data bits goes to rx_bit9 and the data to rx_data. The frame is committed at the middle of the stop bit that follows.
- R4: Each bit is the majority of samples on enable ticks 7, 8 and 9 of the bit, counting the falling-edge tick as tick 1. A single inverted sample on tick 8 does not change the received value.
- R5: If the voted start bit is 1, reception stops at once with no output change, and the receiver resumes edge search so that a following valid frame is received.
- R6: With mp_addr_mode = 1 a frame whose ninth-bit value (stop bit in 8-bit mode, ninth data bit in 9-bit mode) is 0 is discarded. rx_data, rx_bit9 and rx_done keep their values.
- R7: While rx_done is 1 a completed frame is discarded and rx_data and rx_bit9 are unchanged.
- R8: A one-cycle pulse on flag_clr clears rx_done on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Sample enable, 16 pulses per bit period |
| rx_in | input | 1 | Asynchronous serial line, idles high |
| nine_bit_mode | input | 1 | 0: 8-bit frame, 1: 9-bit frame |
| mp_addr_mode | input | 1 | 1: commit only frames whose ninth-bit value is 1 |
| flag_clr | input | 1 | Clears rx_done |
| rx_data | output | 8 | Received data byte |
| rx_bit9 | output | 1 | Stop bit (8-bit mode) or ninth data bit (9-bit mode) |
| rx_done | output | 1 | Frame received flag |

## Verification
The hardest condition to reach from the ports is a disagreement among the three votes of one bit. The line must be inverted for exactly the enable period that holds sample tick 8, and the synchronizer delay must not shift that window. The bench therefore drives the line one enable period at a time, right after each enable edge. Its tick count is aligned to the detected falling edge, so the pulse lands on a chosen sample. The same method places a start bit that is low for only six ticks, or low for seven ticks with two high votes, to reach the abort path.

// File: rtl/mpr_pkg.sv
// Shared types for the majority-vote serial receiver.
package mpr_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RECV = 1'b1
    } rx_state_t;
endpackage

// File: rtl/mpr_sync.sv
// Two-flop synchronizer for the asynchronous serial line.
// Assumes din may change at any time relative to clk; output lags by two cycles.
module mpr_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic meta;

    // Two-stage capture of the line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            dout <= RST_VAL;
        end else begin
            meta <= din;
            dout <= meta;
        end
    end
endmodule

// File: rtl/mpr_voter.sv
// Three-sample majority voter. Captures the line on tick positions MID-2 and
// MID-1 of a bit and votes on position MID, together with the live sample.
// Assumes tidx counts enable ticks within the bit, starting at 0.
module mpr_voter #(
    parameter int OVS = 16,
    parameter int TW  = $clog2(OVS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          active,
    input  logic [TW-1:0] tidx,
    input  logic          rx_s,
    output logic          vote,
    output logic          vote_valid
);
    localparam int MID = OVS / 2;

    logic s_a, s_b;

    // Hold the first two of the three samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_a <= 1'b1;
            s_b <= 1'b1;
        end else if (tick16 && active) begin
            if (tidx == TW'(MID - 2)) s_a <= rx_s;
            if (tidx == TW'(MID - 1)) s_b <= rx_s;
        end
    end

    // Two-of-three decision on the third sample tick.
    always_comb begin
        vote       = (s_a & s_b) | (s_a & rx_s) | (s_b & rx_s);
        vote_valid = tick16 && active && (tidx == TW'(MID));
    end

    // R4: when the two stored samples agree, the third cannot overturn them.
    a_r4_two_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (vote_valid && (s_a == s_b)) |-> (vote == s_a));
endmodule

// File: rtl/mpr_rx.sv
// Majority-vote serial receiver with multiprocessor load condition.
// Assumes tick16 pulses OVS times per bit and the mode inputs are held
// steady during a frame. Commits a frame at the middle of its final bit.
module mpr_rx #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          rx_in,
    input  logic          nine_bit_mode,
    input  logic          mp_addr_mode,
    input  logic          flag_clr,
    output logic [DW-1:0] rx_data,
    output logic          rx_bit9,
    output logic          rx_done
);
    import mpr_pkg::*;

    localparam int TW = $clog2(OVS);
    localparam int BW = $clog2(DW + 3);

    rx_state_t     st;
    logic          rx_s, last_s;
    logic [TW-1:0] tidx;
    logic [BW-1:0] bidx, last_bit;
    logic [DW:0]   sh, shifted;
    logic          vote, vote_valid;
    logic          start_edge, is_last, do_shift, ld_b9, load_ok;
    logic [DW-1:0] ld_data;

    mpr_sync #(.RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_in), .dout(rx_s)
    );

    mpr_voter #(.OVS(OVS), .TW(TW)) u_voter (
        .clk(clk), .rst_n(rst_n), .tick16(tick16),
        .active(st == ST_RECV), .tidx(tidx), .rx_s(rx_s),
        .vote(vote), .vote_valid(vote_valid)
    );

    // Frame decoding: edge detect, last-bit position and load condition.
    always_comb begin
        last_bit   = nine_bit_mode ? BW'(DW + 2) : BW'(DW + 1);
        start_edge = tick16 && (st == ST_IDLE) && last_s && !rx_s;
        is_last    = (bidx == last_bit);
        do_shift   = vote_valid && (bidx != '0) && (bidx <= BW'(DW + 1));
        shifted    = {vote, sh[DW:1]};
        ld_b9      = nine_bit_mode ? sh[DW] : vote;
        ld_data    = nine_bit_mode ? sh[DW-1:0] : shifted[DW-1:0];
        load_ok    = vote_valid && is_last && !rx_done &&
                     (!mp_addr_mode || ld_b9);
    end

    // Sequencer: edge search, tick and bit counting, abort and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            tidx   <= '0;
            bidx   <= '0;
            last_s <= 1'b0;
        end else begin
            if (tick16) last_s <= rx_s;
            case (st)
                ST_IDLE: begin
                    if (start_edge) begin
                        st   <= ST_RECV;
                        tidx <= TW'(1);
                        bidx <= '0;
                    end
                end
                default: begin
                    if (tick16) begin
                        if (tidx == TW'(OVS - 1)) begin
                            tidx <= '0;
                            bidx <= bidx + BW'(1);
                        end else begin
                            tidx <= tidx + TW'(1);
                        end
                    end
                    if (vote_valid && (((bidx == '0) && vote) || is_last))
                        st <= ST_IDLE;
                end
            endcase
        end
    end

    // Shift register collecting data bits LSB first plus the ninth position.
    always_ff @(posedge clk) begin
        if (!rst_n)        sh <= '0;
        else if (do_shift) sh <= shifted;
    end

    // Output registers and the done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_bit9 <= 1'b0;
            rx_done <= 1'b0;
        end else if (load_ok) begin
            rx_data <= ld_data;
            rx_bit9 <= ld_b9;
            rx_done <= 1'b1;
        end else if (flag_clr) begin
            rx_done <= 1'b0;
        end
    end

    // R8: a clear with the flag set leaves the flag low next cycle.
    a_r8_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && rx_done) |=> !rx_done);

    // R7: a set flag without clear freezes the outputs.
    a_r7_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !flag_clr) |=> (rx_done && $stable(rx_data) && $stable(rx_bit9)));

    // R6: in addressing mode only a ninth-bit value of 1 can set the flag.
    a_r6_addr_filter: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rx_done) && $past(mp_addr_mode)) |-> rx_bit9);

    // R5: a start bit voting high returns the receiver to edge search.
    a_r5_false_start: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_RECV) && (bidx == '0) && vote_valid && vote)
        |=> ((st == ST_IDLE) && !$rose(rx_done)));

    // R2: the flag only rises on a sample enable.
    a_r2_flag_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> $past(tick16));
endmodule

// File: tb/mpr_rx_tb.sv
module mpr_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16;
    logic       rx_in = 1'b1;
    logic       nine_bit_mode = 1'b0;
    logic       mp_addr_mode = 1'b0;
    logic       flag_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9;
    logic       rx_done;
    logic [1:0] tcnt = 2'd0;
    int         checks = 0;
    int         errors = 0;
    logic [7:0] exp_data = 8'h00;
    logic       exp_b9 = 1'b0;

    always #5 clk = ~clk;
    always @(negedge clk) tcnt <= tcnt + 2'd1;
    assign tick16 = (tcnt == 2'd3);

    mpr_rx u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(rx_in),
        .nine_bit_mode(nine_bit_mode), .mp_addr_mode(mp_addr_mode),
        .flag_clr(flag_clr), .rx_data(rx_data), .rx_bit9(rx_bit9),
        .rx_done(rx_done)
    );

    // {nine, mp, data[8], ninth/stop, glitch bit (F = none), committed}
    localparam logic [15:0] VEC [8] = '{
        {1'b0, 1'b0, 8'hA5, 1'b1, 4'hF, 1'b1},
        {1'b0, 1'b0, 8'h3C, 1'b0, 4'hF, 1'b1},
        {1'b0, 1'b1, 8'h5A, 1'b0, 4'hF, 1'b0},
        {1'b0, 1'b1, 8'h81, 1'b1, 4'h2, 1'b1},
        {1'b1, 1'b0, 8'h0F, 1'b0, 4'hF, 1'b1},
        {1'b1, 1'b1, 8'hF0, 1'b0, 4'hF, 1'b0},
        {1'b1, 1'b1, 8'h7E, 1'b1, 4'h9, 1'b1},
        {1'b1, 1'b0, 8'h01, 1'b1, 4'h0, 1'b1}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_tick();
        do @(posedge clk); while (tick16 !== 1'b1);
        #1;
    endtask

    // Hold a level for n enable periods.
    task automatic drive(input logic v, input int n);
        for (int t = 0; t < n; t++) begin
            rx_in = v;
            wait_tick();
        end
    endtask

    // Send one frame; the sample on tick 8 of bit 'glitch' is inverted.
    task automatic send_frame(input logic nine, input logic [7:0] d,
                              input logic b9, input int glitch);
        logic [10:0] bits;
        int nb;
        bits = {1'b1, b9, d, 1'b0};
        nb   = nine ? 11 : 10;
        for (int i = 0; i < nb; i++) begin
            for (int t = 1; t <= 16; t++) begin
                rx_in = (i == glitch && t == 8) ? ~bits[i] : bits[i];
                wait_tick();
            end
        end
        drive(1'b1, 4);
    endtask

    task automatic pulse_clr();
        @(posedge clk); #1;
        flag_clr = 1'b1;
        @(posedge clk); #1;
        flag_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        string req;
        repeat (5) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", "rx_data", 32'(rx_data), 32'h0);
        chk("R1", "rx_bit9", 32'(rx_bit9), 32'h0);
        chk("R1", "rx_done", 32'(rx_done), 32'h0);
        rst_n = 1'b1;
        drive(1'b1, 6);

        // Table of frames covering R2, R3, R4 and R6.
        for (int k = 0; k < 8; k++) begin
            logic [15:0] v;
            v = VEC[k];
            nine_bit_mode = v[15];
            mp_addr_mode  = v[14];
            req = v[15] ? "R3" : "R2";
            if (!v[0]) req = "R6";
            if (v[4:1] != 4'hF) req = "R4";
            pulse_clr();
            send_frame(v[15], v[13:6], v[5], (v[4:1] == 4'hF) ? -1 : int'(v[4:1]));
            if (v[0]) begin
                exp_data = v[13:6];
                exp_b9   = v[5];
            end
            chk(req, "rx_done", 32'(rx_done), 32'(v[0]));
            chk(req, "rx_data", 32'(rx_data), 32'(exp_data));
            chk(req, "rx_bit9", 32'(rx_bit9), 32'(exp_b9));
        end

        // R8: clear drops the flag one edge later.
        nine_bit_mode = 1'b0;
        mp_addr_mode  = 1'b0;
        @(posedge clk); #1;
        flag_clr = 1'b1;
        @(posedge clk); #1;
        flag_clr = 1'b0;
        chk("R8", "rx_done after clear", 32'(rx_done), 32'h0);

        // R5: start low for only six ticks, all votes high.
        drive(1'b0, 6);
        drive(1'b1, 200);
        chk("R5", "rx_done short start", 32'(rx_done), 32'h0);
        chk("R5", "rx_data short start", 32'(rx_data), 32'(exp_data));
        // R5: start low for seven ticks, two of three votes high.
        drive(1'b0, 7);
        drive(1'b1, 200);
        chk("R5", "rx_done two-high start", 32'(rx_done), 32'h0);
        // R5: receiver resumed edge search and takes the next frame.
        send_frame(1'b0, 8'hC3, 1'b1, -1);
        chk("R5", "rx_done resumed", 32'(rx_done), 32'h1);
        chk("R5", "rx_data resumed", 32'(rx_data), 32'hC3);
        exp_data = 8'hC3;
        exp_b9   = 1'b1;

        // R7: a frame arriving with the flag set is dropped.
        send_frame(1'b0, 8'h96, 1'b0, -1);
        chk("R7", "rx_done held", 32'(rx_done), 32'h1);
        chk("R7", "rx_data held", 32'(rx_data), 32'(exp_data));
        chk("R7", "rx_bit9 held", 32'(rx_bit9), 32'(exp_b9));

        // R8: cleared flag accepts the next frame again.
        pulse_clr();
        chk("R8", "rx_done cleared", 32'(rx_done), 32'h0);
        send_frame(1'b0, 8'h42, 1'b1, 5);
        chk("R4", "rx_data with glitch", 32'(rx_data), 32'h42);
        chk("R2", "rx_done final", 32'(rx_done), 32'h1);

        finish_run();
    end
endmodule